// File: doc/BRIEF.md
# Inline Upload Writer

This block takes a payload that a command processor pushes as a stream of 32-bit words and writes it into memory as a rectangle of lines. A launch pulse captures four settings: the destination byte address, the destination pitch in bytes, the number of bytes per line and the number of lines. The payload words then arrive on a valid/ready input. The bytes are packed back to back, so line n starts at byte offset n times the line length within the payload. The block unpacks each word into bytes. It places every byte at line base plus column, where the line base starts at the destination address and moves forward by the pitch after each line.

When there is one line, the payload is written contiguously from the destination address and the pitch has no effect. Memory writes leave through a simple request port. Each request carries a word-aligned address, the byte copied into every lane, and a strobe with the one enabled lane. Because each write covers a single byte, a line length, pitch or base address that is not a multiple of four needs no special handling, and payload bytes that run past the end of a line continue on the next line. A done pulse marks the moment the memory port has accepted the last byte.

Top module: `upl_inline_writer`

## Requirements
- R1: After reset, done, wr_valid and in_ready are all low.
- R2: Payload byte k is bits [8(k mod 4)+7 : 8(k mod 4)] of payload word k/4, so byte 0 is in bits [7:0]. The word that holds the final payload byte has in_last set. With a line count of one, the bytes go to consecutive addresses starting at the destination address, whatever the pitch.
- R3: With several lines, byte c of line n is payload byte n*line_bytes+c and is written to destination address + n*pitch + c.
- R4: Each line writes exactly line_bytes bytes and no other address is touched. Every request has wr_addr[1:0]=0 and exactly one strobe bit set, and bit j selects the byte at wr_addr+j.
- R5: Idle cycles between input words do not change the memory contents.
- R6: The settings are captured on the launch cycle. Changing them afterwards does not affect the running transfer.
- R7: A launch pulse while a transfer is in progress is ignored: the transfer keeps its settings and only one done pulse follows.
- R8: A launch with line_bytes=0 or line count=0 raises done in the next cycle. It issues no write and accepts no input word.
- R9: done is a one-cycle pulse, raised in the cycle after the handshake that accepts the final byte, once per transfer.
- R10: in_ready is low while no transfer is running, so a word offered then is held off and is consumed as the first word of the next transfer.
- R11: While wr_valid is high and wr_ready is low, wr_addr, wr_data and wr_strb hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch | input | 1 | Start pulse; captures the settings |
| cfg_dst_addr | input | ADDR_W | Destination byte address |
| cfg_dst_pitch | input | ADDR_W | Byte distance between line starts |
| cfg_line_bytes | input | LEN_W | Bytes per line |
| cfg_line_count | input | CNT_W | Number of lines |
| in_valid | input | 1 | Payload word valid |
| in_ready | output | 1 | Payload word accepted when high with in_valid |
| in_data | input | DATA_W | Payload word, first byte in bits [7:0] |
| in_last | input | 1 | Marks the final payload word |
| wr_valid | output | 1 | Memory write request valid |
| wr_ready | input | 1 | Memory accepts the request |
| wr_addr | output | ADDR_W | Word-aligned write address |
| wr_data | output | DATA_W | Write byte copied into every lane |
| wr_strb | output | DATA_W/8 | Byte-lane enable, one bit set |
| done | output | 1 | Transfer finished pulse |

## Verification
A byte taken from the held word appears on the memory port one cycle later and stays there until wr_ready is seen. done follows the final accepted write by exactly one cycle, and it follows a zero-size launch by one cycle. The bench drives inputs and reads in_ready and the other outputs at falling edges. A rising-edge monitor records the cycle number of each write handshake and each done pulse, so the one-cycle spacing is checked by comparing counts, not by guessing a sample point. The memory image is compared byte for byte against an image the bench builds from the settings, both with free-flowing and with randomly stalled wr_ready.

// File: rtl/upl_pkg.sv
// Package: shared types of the inline upload writer.
// Assumes: nothing beyond a single clock domain.
package upl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } upl_state_e;
endpackage

// File: rtl/upl_unpack.sv
// Module: holds one payload word and hands it out one byte at a time,
// lowest byte first.
// Assumes: en is high only while a transfer runs; flush drops any bytes
// left over from the held word.
module upl_unpack #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flush,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_take,
    output logic              word_last
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [DATA_W-1:0] word_q;
    logic [LANE_W-1:0] idx_q;
    logic              full_q;
    logic              last_q;

    // accept a new word only when the holding register is empty
    assign in_ready   = en && !full_q;
    assign byte_valid = full_q;
    assign byte_data  = word_q[{idx_q, 3'b000} +: 8];
    assign word_last  = last_q;

    // load words and step through their bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
            last_q <= 1'b0;
        end else if (flush) begin
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            idx_q  <= '0;
            full_q <= 1'b1;
            last_q <= in_last;
        end else if (byte_take) begin
            if (idx_q == LANE_W'(LANES - 1)) begin
                idx_q  <= '0;
                full_q <= 1'b0;
            end else begin
                idx_q <= idx_q + LANE_W'(1);
            end
        end
    end

    // a byte is only taken when one is held
    p_take_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_take |-> full_q);
endmodule

// File: rtl/upl_addr_gen.sv
// Module: captures the region settings at load and walks column and line
// counters, giving the destination byte address of the next payload byte.
// Assumes: load only when line length and line count are both non-zero.
module upl_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_pitch,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  cfg_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_byte
);
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] pitch_q;
    logic [LEN_W-1:0]  len_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [LEN_W-1:0]  col_q;
    logic [CNT_W-1:0]  line_q;
    logic              line_end;

    // column wraps at the line length; the final byte ends the last line
    assign line_end  = (col_q == len_q - LEN_W'(1));
    assign last_byte = line_end && (line_q == cnt_q - CNT_W'(1));
    assign cur_addr  = base_q + ADDR_W'(col_q);

    // capture settings at load, then advance one byte per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            pitch_q <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            col_q   <= '0;
            line_q  <= '0;
        end else if (load) begin
            base_q  <= cfg_addr;
            pitch_q <= cfg_pitch;
            len_q   <= cfg_len;
            cnt_q   <= cfg_cnt;
            col_q   <= '0;
            line_q  <= '0;
        end else if (step) begin
            if (line_end) begin
                col_q  <= '0;
                line_q <= line_q + CNT_W'(1);
                base_q <= base_q + pitch_q;
            end else begin
                col_q <= col_q + LEN_W'(1);
            end
        end
    end

    // a stepped byte always lies inside the current line and region
    p_col_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (col_q < len_q) && (line_q < cnt_q));
endmodule

// File: rtl/upl_wr_port.sv
// Module: one-entry output register for byte writes; turns a byte address
// into a word address plus a single-lane strobe.
// Assumes: issue is raised only when can_issue is high.
module upl_wr_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue,
    input  logic [ADDR_W-1:0]   byte_addr,
    input  logic [7:0]          byte_data,
    output logic                can_issue,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_strb
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_W = $clog2(LANES);

    // the slot is free when empty or being emptied this cycle
    assign can_issue = !wr_valid || wr_ready;

    // load a request or retire the accepted one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
        end else if (issue) begin
            wr_valid <= 1'b1;
            wr_addr  <= {byte_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
            wr_data  <= {LANES{byte_data}};
            wr_strb  <= LANES'(1) << byte_addr[LANE_W-1:0];
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr)
                                    && $stable(wr_data) && $stable(wr_strb));
    p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($countones(wr_strb) == 1));
endmodule

// File: rtl/upl_inline_writer.sv
// Module: inline upload writer top. Sequences launch, byte placement and
// completion across the unpacker, address walker and write register.
// Assumes: launch is a single-cycle pulse; the payload holds at least
// line_bytes*line_count bytes, and its final word carries in_last.
module upl_inline_writer #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [ADDR_W-1:0]   cfg_dst_addr,
    input  logic [ADDR_W-1:0]   cfg_dst_pitch,
    input  logic [LEN_W-1:0]    cfg_line_bytes,
    input  logic [CNT_W-1:0]    cfg_line_count,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_last,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W/8-1:0] wr_strb,
    output logic                done
);
    import upl_pkg::*;

    upl_state_e        state_q;
    logic              launch_ok, empty_cfg, load, take, fire, flush;
    logic              byte_valid, can_issue, last_byte, word_last;
    logic [7:0]        byte_data;
    logic [ADDR_W-1:0] cur_addr;

    // launch is honoured only when idle; empty regions finish at once
    assign launch_ok = (state_q == ST_IDLE) && launch;
    assign empty_cfg = (cfg_line_bytes == '0) || (cfg_line_count == '0);
    assign load      = launch_ok && !empty_cfg;
    assign take      = (state_q == ST_RUN) && byte_valid && can_issue;
    assign fire      = wr_valid && wr_ready;
    assign flush     = load || ((state_q == ST_DRAIN) && fire);

    upl_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .en(state_q == ST_RUN), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_last(in_last), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_take(take), .word_last(word_last)
    );

    upl_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .cfg_addr(cfg_dst_addr),
        .cfg_pitch(cfg_dst_pitch), .cfg_len(cfg_line_bytes),
        .cfg_cnt(cfg_line_count), .step(take), .cur_addr(cur_addr),
        .last_byte(last_byte)
    );

    upl_wr_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .issue(take), .byte_addr(cur_addr),
        .byte_data(byte_data), .can_issue(can_issue), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb)
    );

    // transfer state machine and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (launch_ok) begin
                        if (empty_cfg) done <= 1'b1;
                        else           state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (take && last_byte) state_q <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (fire) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_no_input_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |-> !in_ready);
    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !wr_valid);
    p_done_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(launch)) |-> $past(wr_valid && wr_ready));
    p_last_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DRAIN) && fire) |-> word_last);
endmodule

// File: tb/upl_inline_writer_test.sv
module upl_inline_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [15:0] cfg_dst_addr = '0, cfg_dst_pitch = '0;
    logic [11:0] cfg_line_bytes = '0;
    logic [7:0]  cfg_line_count = '0;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, wr_valid, done;
    logic        wr_ready = 1'b1;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;

    int checks = 0, errors = 0;
    int cyc = 0, wr_cnt = 0, done_cnt = 0, last_wr_cyc = -1, done_cyc = -1;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [7:0] mem [256];
    logic [7:0] expm [256];
    logic [7:0] snap [256];

    upl_inline_writer uut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cfg_dst_addr(cfg_dst_addr),
        .cfg_dst_pitch(cfg_dst_pitch), .cfg_line_bytes(cfg_line_bytes),
        .cfg_line_count(cfg_line_count), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_strb(wr_strb), .done(done)
    );

    always #2 clk = ~clk;

    // memory model and event recorder
    always @(posedge clk) begin
        if (wr_valid && wr_ready) begin
            for (int l = 0; l < 4; l++)
                if (wr_strb[l]) mem[(int'(wr_addr) + l) % 256] = wr_data[l*8 +: 8];
            wr_cnt++;
            last_wr_cyc = cyc;
        end
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        cyc++;
    end

    // memory back-pressure pattern
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready = stall_en ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] pbyte(input int i, input int seed);
        return 8'(i * 29 + seed * 7 + 3);
    endfunction

    task automatic build_exp(input int addr, input int pitch, input int len,
                             input int cnt, input int seed);
        for (int a = 0; a < 256; a++) expm[a] = 8'hEE;
        for (int n = 0; n < cnt; n++)
            for (int c = 0; c < len; c++)
                expm[(addr + n * pitch + c) % 256] = pbyte(n * len + c, seed);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0, first = -1;
        for (int a = 0; a < 256; a++)
            if (mem[a] !== expm[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        check(bad == 0, req, (first < 0) ? 0 : int'(mem[first]),
              (first < 0) ? 0 : int'(expm[first]));
    endtask

    function automatic logic [31:0] mkword(input int w, input int total, input int seed);
        logic [31:0] v = '0;
        for (int b = 0; b < 4; b++)
            if (4 * w + b < total) v[b*8 +: 8] = pbyte(4 * w + b, seed);
        return v;
    endfunction

    task automatic send_word(input logic [31:0] d, input bit last);
        bit hs;
        in_valid = 1'b1; in_data = d; in_last = last;
        do begin
            hs = in_ready;
            @(negedge clk);
        end while (!hs);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // generic transfer; settings, options and requirement tag
    task automatic run_xfer(input int addr, input int pitch, input int len, input int cnt,
                            input int gap, input bit stall, input int seed,
                            input bit scramble, input bit relaunch, input bit prehold,
                            input string req);
        int total = len * cnt;
        int nw = (total + 3) / 4;
        int d0, t;
        for (int a = 0; a < 256; a++) mem[a] = 8'hEE;
        wr_cnt = 0;
        d0 = done_cnt;
        stall_en = stall;
        @(negedge clk);
        if (prehold) begin
            // R10: word offered while idle is held off
            in_valid = 1'b1; in_data = mkword(0, total, seed); in_last = (nw == 1);
            for (int k = 0; k < 5; k++) begin
                check(in_ready == 1'b0, "R10 in_ready while idle", int'(in_ready), 0);
                @(negedge clk);
            end
        end
        cfg_dst_addr = 16'(addr); cfg_dst_pitch = 16'(pitch);
        cfg_line_bytes = 12'(len); cfg_line_count = 8'(cnt);
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        if (scramble) begin
            cfg_dst_addr = 16'h00C8; cfg_dst_pitch = 16'd1;
            cfg_line_bytes = 12'd2; cfg_line_count = 8'd9;
        end
        for (int w = 0; w < nw; w++) begin
            send_word(mkword(w, total, seed), w == nw - 1);
            if (relaunch && w == 1) begin
                cfg_dst_addr = 16'h00D0; cfg_line_bytes = 12'd1; cfg_line_count = 8'd1;
                launch = 1'b1;
                @(negedge clk);
                launch = 1'b0;
            end
            for (int g = 0; g < gap; g++) @(negedge clk);
        end
        t = 0;
        while (done_cnt == d0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        stall_en = 1'b0;
        check(done_cnt == d0 + 1, {req, " R9 done count"}, done_cnt - d0, 1);
        check(done_cyc == last_wr_cyc + 1, {req, " R9 done timing"}, done_cyc, last_wr_cyc + 1);
        check(wr_cnt == total, {req, " R4 write count"}, wr_cnt, total);
        build_exp(addr, pitch, len, cnt, seed);
        cmp_mem({req, " memory image"});
    endtask

    task automatic t_reset();
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(wr_valid == 1'b0, "R1 wr_valid after reset", int'(wr_valid), 0);
        check(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    endtask

    task automatic t_single_line();   // R2
        run_xfer(16'h13, 5, 10, 1, 0, 0, 1, 0, 0, 0, "R2 single line");
    endtask

    task automatic t_multi_line();    // R3
        run_xfer(16'h41, 7, 3, 4, 0, 0, 2, 0, 0, 0, "R3 multi line");
    endtask

    task automatic t_stalled();       // R11 R4
        run_xfer(16'h06, 8, 6, 5, 0, 1, 3, 0, 0, 0, "R11 stalled memory");
    endtask

    task automatic t_gaps();          // R5
        int bad = 0;
        run_xfer(16'h22, 9, 5, 3, 0, 0, 4, 0, 0, 0, "R5 burst");
        for (int a = 0; a < 256; a++) snap[a] = mem[a];
        run_xfer(16'h22, 9, 5, 3, 3, 0, 4, 0, 0, 0, "R5 gapped");
        for (int a = 0; a < 256; a++) if (snap[a] !== mem[a]) bad++;
        check(bad == 0, "R5 burst and gapped images equal", bad, 0);
    endtask

    task automatic t_scramble();      // R6
        run_xfer(16'h31, 12, 7, 3, 1, 1, 5, 1, 0, 0, "R6 settings changed mid-run");
    endtask

    task automatic t_relaunch();      // R7
        run_xfer(16'h50, 10, 4, 4, 0, 1, 6, 0, 1, 0, "R7 launch while busy");
    endtask

    task automatic t_idle_input();    // R10
        run_xfer(16'h80, 6, 5, 2, 0, 0, 7, 0, 0, 1, "R10 held word");
    endtask

    task automatic t_empty(input int len, input int cnt);   // R8
        int d0 = done_cnt, w0;
        bit rdy = 1'b0;
        wr_cnt = 0; w0 = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = 32'h12345678; in_last = 1'b1;
        cfg_line_bytes = 12'(len); cfg_line_count = 8'(cnt); cfg_dst_addr = 16'h10;
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
        // done is registered at the launch edge; seen by the monitor next edge
        for (int k = 0; k < 4; k++) begin
            rdy = rdy | in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0;
        check(done_cnt == d0 + 1, "R8 done for empty region", done_cnt - d0, 1);
        check(wr_cnt == w0, "R8 no writes for empty region", wr_cnt, w0);
        check(rdy == 1'b0, "R8 no input accepted", int'(rdy), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_line();
        t_multi_line();
        t_stalled();
        t_gaps();
        t_scramble();
        t_relaunch();
        t_idle_input();
        t_empty(0, 3);
        t_empty(4, 0);
        report();
    end

    // watchdog
    initial begin
        wait (cyc > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        report();
    end
endmodule